// File: doc/BRIEF.md
# Serial ADC Frame and Power-Mode Controller

This block is the digital sequencer of a 12-bit successive-approximation converter. An active-low chip select and an external serial clock frame each conversion. A chip-select fall puts the sampler into hold, captures the result offered by the converter core, and starts a 16-bit read-out. The read-out sends four zero bits and then the 12-bit result, most significant bit first, one bit for each falling serial-clock edge. The data output is modelled as a line plus a drive enable.

Both external strobes pass through synchronizers into a free-running system clock, and all counting is done in that domain. The number of serial-clock falling edges seen before chip select rises sets the power state. An early rise keeps the block powered. A rise in the middle band powers it down. A late rise aborts the read but stays powered.

A chip-select fall while powered down starts a wake-up frame. The wake-up completes only if that frame reaches ten falling edges. Full power is then reached after a programmable number of system-clock cycles.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset the data enable is low, the data line is 0, track is high, valid is low and mode is 0 (powered; mode codes: 0 powered, 1 waking, 2 powered down).
- R2: In powered mode a chip-select fall raises the data enable, drives the first zero bit, drops track (hold) and pulses conv_start_o while the mode stays 0.
- R3: A full frame presents the word {4'b0000, result} from bit 15 down to bit 0. Bit 15 is visible after chip select falls, and bit 15-k is visible after the k-th serial-clock fall.
- R4: The data enable drops on the 16th serial-clock fall of a normal frame, and valid then rises and stays high until the next chip-select fall.
- R5: In a normal frame track stays low through the 13th serial-clock fall and rises on the next serial-clock rise.
- R6: A chip-select rise after fewer than 2 serial-clock falls aborts the frame: enable low, valid low, mode stays 0, track high.
- R7: A chip-select rise after 2 to 9 serial-clock falls aborts the frame, sets mode 2, and drops track. The bound of 2 falls is inclusive.
- R8: A chip-select rise after 10 to 15 serial-clock falls aborts the frame and leaves mode at 0 with track high. The bound of 10 falls is inclusive.
- R9: A chip-select fall in mode 2 sets mode 1. Track rises on the first serial-clock edge of that frame. Valid stays low after the frame completes.
- R10: If the wake-up frame ends with chip select rising after fewer than 10 falls, the mode returns to 2.
- R11: After a wake-up frame of 10 or more falls, mode stays 1 until about WAKE_CYCLES system clocks after the chip-select fall, then becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idles high, asynchronous |
| result_i | input | RES_W | Conversion result from the converter core |
| sdata_o | output | 1 | Serial data bit, 0 while not driven |
| sdata_oe_o | output | 1 | Data output enable (low = three-state) |
| track_o | output | 1 | 1 = track, 0 = hold or idle |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| mode_o | output | 2 | Power mode: 0 powered, 1 waking, 2 down |
| valid_o | output | 1 | Last frame delivered a valid result |

## Verification
The assertions assume that chip select and the serial clock change slowly against the system clock: each level is held for at least three system cycles, and a chip-select edge and a serial-clock edge never land in the same synchronized cycle. The bench keeps within these limits. It drives both strobes on the falling system-clock edge and holds every serial-clock half period for four system cycles. Between frames it leaves chip select high for several cycles. The result input is held stable across every chip-select fall.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic [1:0] {
    PM_UP   = 2'd0,
    PM_WAKE = 2'd1,
    PM_DOWN = 2'd2
  } pmode_e;
endpackage

// File: rtl/afc_edge_sync.sv
module afc_edge_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= INIT;
        else         chain_q[0] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= INIT;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  // Last stage is the history bit for edge detection.
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/afc_frame.sv
module afc_frame #(
  parameter int FRAME_BITS = 16,
  parameter int RES_W      = 12,
  localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic [RES_W-1:0] result_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             abort_o,
  output logic             sdata_o,
  output logic             oe_o
);
  localparam int LEAD = FRAME_BITS - RES_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
      done_o   <= 1'b0;
      abort_o  <= 1'b0;
      oe_o     <= 1'b0;
      shift_q  <= '0;
    end else begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      if (cs_fall_i) begin
        active_o <= 1'b1;
        cnt_o    <= '0;
        oe_o     <= 1'b1;
        shift_q  <= {{LEAD{1'b0}}, result_i};
      end else if (active_o) begin
        if (cs_rise_i) begin
          active_o <= 1'b0;
          oe_o     <= 1'b0;
          abort_o  <= 1'b1;
        end else if (sclk_fall_i) begin
          cnt_o   <= cnt_o + 1'b1;
          shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
          if (cnt_o == LAST) begin
            active_o <= 1'b0;
            oe_o     <= 1'b0;
            done_o   <= 1'b1;
          end
        end
      end
    end
  end

  assign sdata_o = oe_o & shift_q[FRAME_BITS-1];
endmodule

// File: rtl/afc_mode.sv
module afc_mode
  import afc_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int DOWN_EDGE   = 2,
  parameter int KEEP_EDGE   = 10,
  parameter int TRACK_EDGE  = 13,
  parameter int WAKE_CYCLES = 64,
  localparam int WC_W       = $clog2(WAKE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             sclk_fall_i,
  input  logic             sclk_rise_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             done_i,
  input  logic             abort_i,
  output pmode_e           mode_o,
  output logic             track_o,
  output logic             valid_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] DOWN_C  = CNT_W'(DOWN_EDGE);
  localparam logic [CNT_W-1:0] KEEP_C  = CNT_W'(KEEP_EDGE);
  localparam logic [CNT_W-1:0] TRACK_C = CNT_W'(TRACK_EDGE);

  logic [WC_W-1:0] wake_cnt_q;
  logic            wake_frame_q;
  logic            go_down;
  logic            track_set;

  // Wake frame: any abort short of the keep edge. Normal frame: the middle band only.
  assign go_down = wake_frame_q ? (cnt_i < KEEP_C)
                                : (cnt_i >= DOWN_C && cnt_i < KEEP_C);
  assign track_set = active_i && (wake_frame_q ? (sclk_rise_i || sclk_fall_i)
                                               : (sclk_rise_i && cnt_i >= TRACK_C));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o       <= PM_UP;
      wake_cnt_q   <= '0;
      wake_frame_q <= 1'b0;
      track_o      <= 1'b1;
      valid_o      <= 1'b0;
      start_o      <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (cs_fall_i) begin
        valid_o <= 1'b0;
        if (mode_o == PM_UP) begin
          track_o      <= 1'b0;
          wake_frame_q <= 1'b0;
          start_o      <= 1'b1;
        end else begin
          wake_frame_q <= 1'b1;
          if (mode_o == PM_DOWN) begin
            mode_o     <= PM_WAKE;
            wake_cnt_q <= WC_W'(WAKE_CYCLES);
          end
        end
      end else if (abort_i) begin
        wake_frame_q <= 1'b0;
        if (go_down) begin
          mode_o  <= PM_DOWN;
          track_o <= 1'b0;
        end else begin
          track_o <= 1'b1;
        end
      end else if (done_i) begin
        wake_frame_q <= 1'b0;
        if (!wake_frame_q) valid_o <= 1'b1;
      end else begin
        if (track_set) track_o <= 1'b1;
        if (mode_o == PM_WAKE) begin
          if (wake_cnt_q != '0) begin
            wake_cnt_q <= wake_cnt_q - 1'b1;
          end else if (!wake_frame_q) begin
            mode_o  <= PM_UP;
            track_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import afc_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int DOWN_EDGE   = 2,
  parameter int KEEP_EDGE   = 10,
  parameter int TRACK_EDGE  = 13,
  parameter int WAKE_CYCLES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  output logic             track_o,
  output logic             conv_start_o,
  output logic [1:0]       mode_o,
  output logic             valid_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic             cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic             frame_active, frame_done, frame_abort;
  logic [CNT_W-1:0] frame_cnt;
  pmode_e           mode;

  afc_edge_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
    .clk_i, .rst_ni, .async_i(cs_ni), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  afc_edge_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sclk_sync (
    .clk_i, .rst_ni, .async_i(sclk_i), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  afc_frame #(.FRAME_BITS(FRAME_BITS), .RES_W(RES_W)) u_frame (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sclk_fall_i(sclk_fall),
    .result_i,
    .active_o(frame_active), .cnt_o(frame_cnt),
    .done_o(frame_done), .abort_o(frame_abort),
    .sdata_o, .oe_o(sdata_oe_o)
  );

  afc_mode #(
    .CNT_W(CNT_W), .DOWN_EDGE(DOWN_EDGE), .KEEP_EDGE(KEEP_EDGE),
    .TRACK_EDGE(TRACK_EDGE), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_mode (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .active_i(frame_active), .cnt_i(frame_cnt),
    .done_i(frame_done), .abort_i(frame_abort),
    .mode_o(mode), .track_o, .valid_o, .start_o(conv_start_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/afc_checker.sv
module afc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_fall,
  input logic       cs_rise,
  input logic       sclk_fall,
  input logic       frame_done,
  input logic       frame_abort,
  input logic       sdata_oe_o,
  input logic       track_o,
  input logic       conv_start_o,
  input logic [1:0] mode_o,
  input logic       valid_o
);
  assert_oe_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> $past(cs_fall));

  assert_start_powered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (mode_o == 2'd0) && !track_o);

  assert_oe_stops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdata_oe_o) |-> $past(sclk_fall || cs_rise));

  assert_valid_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(frame_done) && mode_o == 2'd0);

  assert_down_on_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> $past(frame_abort) && !track_o);

  assert_wake_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && $past(mode_o) == 2'd1) |-> !sdata_oe_o);

  assert_no_valid_unpowered_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0) |-> !valid_o);
endmodule

bind adc_frame_ctrl afc_checker u_afc_checker (
  .clk_i, .rst_ni, .cs_fall, .cs_rise, .sclk_fall, .frame_done, .frame_abort,
  .sdata_oe_o, .track_o, .conv_start_o, .mode_o, .valid_o
);

// File: tb/adc_frame_ctrl_test.sv
module adc_frame_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WAKE       = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] res = '0;
  logic        sdata, sdata_oe, track, conv_start, valid;
  logic [1:0]  mode;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [15:0] word;
  logic        trk_f [0:16];
  logic        trk_r [0:16];
  logic        oe_first, oe_last;

  adc_frame_ctrl #(.WAKE_CYCLES(WAKE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .result_i(res),
    .sdata_o(sdata), .sdata_oe_o(sdata_oe), .track_o(track),
    .conv_start_o(conv_start), .mode_o(mode), .valid_o(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs n serial-clock pulses inside one chip-select window.
  task automatic frame(input int n);
    word = '0;
    cs_n = 1'b0;
    idle(HALF);
    word[15] = sdata;
    oe_first = sdata_oe;
    trk_f[0] = track;
    for (int i = 1; i <= n; i++) begin
      sclk = 1'b0;
      idle(HALF);
      if (i < 16) word[15-i] = sdata;
      trk_f[i] = track;
      oe_last = sdata_oe;
      sclk = 1'b1;
      idle(HALF);
      trk_r[i] = track;
    end
    cs_n = 1'b1;
    idle(HALF + 2);
  endtask

  task automatic t_reset;
    chk("R1 oe", sdata_oe, 0);
    chk("R1 sdata", sdata, 0);
    chk("R1 track", track, 1);
    chk("R1 valid", valid, 0);
    chk("R1 mode", mode, 0);
  endtask

  task automatic t_normal(input logic [11:0] v);
    res = v;
    frame(16);
    chk("R2 oe on at cs fall", oe_first, 1);
    chk("R2 hold at cs fall", trk_f[0], 0);
    chk("R3 word", word, {4'b0000, v});
    chk("R4 oe off at 16th fall", oe_last, 0);
    chk("R4 valid", valid, 1);
    chk("R5 hold after 12th rise", trk_r[12], 0);
    chk("R5 hold after 13th fall", trk_f[13], 0);
    chk("R5 track after 13th rise", trk_r[13], 1);
    chk("R5 mode", mode, 0);
  endtask

  task automatic t_abort_keep(input int n, input string req);
    frame(n);
    chk({req, " oe"}, sdata_oe, 0);
    chk({req, " valid"}, valid, 0);
    chk({req, " mode"}, mode, 0);
    chk({req, " track"}, track, 1);
  endtask

  task automatic t_abort_down(input int n);
    frame(n);
    chk("R7 oe", sdata_oe, 0);
    chk("R7 mode down", mode, 2);
    chk("R7 track low", track, 0);
  endtask

  task automatic t_wake_abort(input int n);
    frame(n);
    chk("R9 track after first edge", trk_f[1], 1);
    chk("R10 mode back down", mode, 2);
    chk("R10 oe", sdata_oe, 0);
  endtask

  task automatic t_wake_full;
    frame(16);
    chk("R9 hold before first edge", trk_f[0], 0);
    chk("R9 track after first edge", trk_f[1], 1);
    chk("R9 valid stays low", valid, 0);
    chk("R11 still waking", mode, 1);
    idle(WAKE);
    chk("R11 powered after wake count", mode, 0);
    chk("R11 track", track, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_normal(12'hA5C);
    t_normal(12'hFFF);
    t_abort_keep(1, "R6");
    t_abort_keep(0, "R6");
    t_abort_keep(10, "R8");
    t_abort_keep(15, "R8");
    t_abort_down(2);
    t_wake_abort(9);
    t_wake_full();
    t_normal(12'h3C7);
    t_abort_down(9);
    t_wake_full();
    t_normal(12'h001);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule